// File: doc/BRIEF.md
# UART Register-Access Control Slave

This block is the target end of a half-duplex serial control line. A host sends framed packets over one line; the slave decodes them, reads or writes a small internal register file, and answers on a second line whose driver it enables only while it replies. Every packet opens with a fixed synchronisation byte. The slave then compares the device address with its own and, on a match, either stages write data or gathers read data and replies. Packets for any other address go, byte by byte, to a forwarding port for a downstream bridge.

The bit period, in clock cycles, comes from an external rate detector on `bit_ticks`. Written data waits in a staging buffer and reaches the registers only once the acknowledge character has fully left the transmitter. A packet that is cut short or corrupted therefore changes nothing. Register 0 holds the device address, so the address can be changed over the line itself.

Top module: `uart_reg_slave`

## Requirements
- R1: After reset `tx_o` is 1, `tx_oe` is 0, `fwd_valid` is 0, and register 0 (the device address) holds 0x80 while all other registers hold 0x00.
- R2: Every character in both directions is 11 bits, each lasting `bit_ticks` clock cycles, in this order: a start bit of 0, eight data bits least significant first, an even parity bit (so data plus parity have an even count of ones), and a stop bit of 1.
- R3: A packet begins only with the byte 0x79. Any other byte received while waiting for a packet is ignored and gets no reply.
- R4: A write packet is 0x79, then a device byte equal to the own address with bit 0 cleared, then a register index, then a count N, then N data bytes. The slave answers with the single byte 0xC3, and register index+k then reads back data byte k.
- R5: Staged write data reaches the registers in the cycle the acknowledge character's stop bit ends, and not before. A packet that starts right after that acknowledge already sees the new values.
- R6: A read packet is 0x79, then the own address with bit 0 set, then an index, then a count N. The slave replies 0xC3 followed by N bytes taken from index, index+1, and so on in ascending order. Indices at or above the register count return 0x00.
- R7: Write bytes aimed at indices at or above the register count are dropped, and registers in range keep their values.
- R8: A device byte whose upper seven bits differ from the own address gets no reply. That byte and every later byte of the packet appear on `fwd_data` with a one-cycle `fwd_valid` pulse each, and `fwd_sop` is high together with the first of them.
- R9: A parity error or a stop bit of 0 in any byte abandons the packet. No acknowledge is sent and all write data staged for that packet is discarded.
- R10: If the line stays idle for 16 bit times, the parser goes back to waiting for 0x79, so bytes arriving after such a gap in mid-packet are ignored.
- R11: `tx_oe` is high only from the start of a reply to the end of its last stop bit, `tx_o` is 1 whenever `tx_oe` is 0, and exactly one `tx_oe` pulse occurs per acknowledged packet.
- R12: The own address is register 0. Bit 0 of that register plays no part in address matching, and a new value applies from the packet that follows the acknowledge of the write that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_ticks | input | 16 | Bit period in clock cycles, from the rate detector |
| rx_i | input | 1 | Serial line from the host, idles high |
| tx_o | output | 1 | Serial reply line, idles high |
| tx_oe | output | 1 | Driver enable for the reply line |
| fwd_valid | output | 1 | One-cycle strobe: a byte for another device is on `fwd_data` |
| fwd_sop | output | 1 | Marks the first forwarded byte of a packet |
| fwd_data | output | 8 | Forwarded byte |

## Verification
Two things can meet in the same clock cycle: the commit of staged write data at the end of the acknowledge, and the start of the host's next packet, whose device byte is then matched against register 0. The bench provokes this by writing a new device address and sending a read to that new address as soon as `tx_oe` falls, without any idle gap. It passes only if the slave answers at the new address with the value just written, and if the old address is then forwarded instead of answered. Further cases drop a packet through a parity error and through a bad stop bit, each time after data has been staged, and then read the registers back to confirm nothing was committed.

// File: rtl/uart_ctl_pkg.sv
// Package: shared constants and parser state type for the UART register slave.
// Assumes 8-bit characters and an 8-bit register index on the line.
package uart_ctl_pkg;
    localparam logic [7:0] SYNC_BYTE = 8'h79;
    localparam logic [7:0] ACK_BYTE  = 8'hC3;

    typedef enum logic [2:0] {
        P_WAIT_SYNC,
        P_DEVICE,
        P_INDEX,
        P_COUNT,
        P_WDATA,
        P_FORWARD,
        P_REPLY
    } parse_state_e;
endpackage

// File: rtl/uart_rs_rx.sv
// Receiver: synchronises the line, finds start bits, samples mid-bit,
// checks even parity and the stop bit, and signals an idle gap of
// IDLE_BITS bit times. Assumes bit_ticks >= 4 and stable during a character.
// While en is low the receiver is held idle and its gap timer is cleared.
module uart_rs_rx #(
    parameter int TICKW     = 16,
    parameter int IDLE_BITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [TICKW-1:0] bit_ticks,
    input  logic             rx_i,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic             frame_err,
    output logic             idle_to
);
    localparam int IBW = $clog2(IDLE_BITS + 1);
    localparam logic [IBW-1:0] IB_LAST = IBW'(IDLE_BITS - 1);

    logic             s1, s2, prev;
    logic             busy;
    logic [TICKW-1:0] cnt;
    logic [TICKW-1:0] itick;
    logic [IBW-1:0]   ibits;
    logic             idle_done;
    logic [3:0]       bitn;
    logic [7:0]       shreg;
    logic             par;
    logic             fall;

    assign fall      = prev & ~s2;
    assign byte_data = shreg;

    // Line synchroniser, character sampler and idle-gap timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1         <= 1'b1;
            s2         <= 1'b1;
            prev       <= 1'b1;
            busy       <= 1'b0;
            cnt        <= '0;
            itick      <= '0;
            ibits      <= '0;
            idle_done  <= 1'b0;
            bitn       <= '0;
            shreg      <= '0;
            par        <= 1'b0;
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
            idle_to    <= 1'b0;
        end else begin
            s1         <= rx_i;
            s2         <= s1;
            prev       <= s2;
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
            idle_to    <= 1'b0;
            if (!en) begin
                busy      <= 1'b0;
                itick     <= '0;
                ibits     <= '0;
                idle_done <= 1'b0;
            end else if (!busy) begin
                if (fall) begin
                    busy      <= 1'b1;
                    cnt       <= {1'b0, bit_ticks[TICKW-1:1]};
                    bitn      <= '0;
                    itick     <= '0;
                    ibits     <= '0;
                    idle_done <= 1'b0;
                end else if (!idle_done) begin
                    if (itick >= bit_ticks - 1'b1) begin
                        itick <= '0;
                        if (ibits == IB_LAST) begin
                            idle_to   <= 1'b1;
                            idle_done <= 1'b1;
                            ibits     <= '0;
                        end else begin
                            ibits <= ibits + 1'b1;
                        end
                    end else begin
                        itick <= itick + 1'b1;
                    end
                end
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                cnt  <= bit_ticks - 1'b1;
                bitn <= bitn + 1'b1;
                if (bitn == 4'd0) begin
                    if (s2) begin
                        busy <= 1'b0;
                    end
                end else if (bitn <= 4'd8) begin
                    shreg <= {s2, shreg[7:1]};
                end else if (bitn == 4'd9) begin
                    par <= s2;
                end else begin
                    busy <= 1'b0;
                    if (s2 && !(^{shreg, par})) begin
                        byte_valid <= 1'b1;
                    end else begin
                        frame_err <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_rs_tx.sv
// Transmitter: sends one 11-bit character (start, data LSB first, even
// parity, stop) per start pulse, each bit bit_ticks cycles long. Assumes
// start is only pulsed while busy is low. done pulses as the stop bit ends.
module uart_rs_tx #(
    parameter int TICKW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TICKW-1:0] bit_ticks,
    input  logic             start,
    input  logic [7:0]       data,
    output logic             line,
    output logic             busy,
    output logic             done
);
    logic [10:0]      sh;
    logic [TICKW-1:0] cnt;
    logic [3:0]       left;

    assign line = busy ? sh[0] : 1'b1;

    // Character shifter with per-bit period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            cnt  <= '0;
            left <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    sh   <= {1'b1, ^data, data, 1'b0};
                    cnt  <= bit_ticks - 1'b1;
                    left <= 4'd10;
                    busy <= 1'b1;
                end
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (left == 4'd0) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                sh   <= {1'b1, sh[10:1]};
                left <= left - 1'b1;
                cnt  <= bit_ticks - 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_rs_regs.sv
// Register file with a staging buffer: writes land in per-entry pending
// slots and move to the live registers on commit; discard empties the
// slots. Entry 0 resets to ADDR_RST and is exported as the own address.
module uart_rs_regs #(
    parameter int         NREGS    = 16,
    parameter logic [7:0] ADDR_RST = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stage_en,
    input  logic [$clog2(NREGS)-1:0] stage_idx,
    input  logic [7:0]               stage_data,
    input  logic                     commit,
    input  logic                     discard,
    input  logic [$clog2(NREGS)-1:0] rd_idx,
    output logic [7:0]               rd_data,
    output logic [7:0]               own_addr
);
    localparam int RAW = $clog2(NREGS);

    logic [NREGS*8-1:0] live_flat;

    for (genvar i = 0; i < NREGS; i++) begin : g_ent
        localparam logic [7:0] RSTV = (i == 0) ? ADDR_RST : 8'h00;
        logic [7:0] val_q;
        logic [7:0] pend_q;
        logic       pend_v;

        // One entry: stage, commit or discard its pending byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q  <= RSTV;
                pend_q <= 8'h00;
                pend_v <= 1'b0;
            end else if (commit) begin
                if (pend_v) begin
                    val_q <= pend_q;
                end
                pend_v <= 1'b0;
            end else if (discard) begin
                pend_v <= 1'b0;
            end else if (stage_en && stage_idx == RAW'(i)) begin
                pend_q <= stage_data;
                pend_v <= 1'b1;
            end
        end

        assign live_flat[i*8 +: 8] = val_q;
    end

    assign rd_data  = live_flat[rd_idx*8 +: 8];
    assign own_addr = live_flat[7:0];
endmodule

// File: rtl/uart_reg_slave.sv
// Top: packet parser and reply sequencer of the UART register slave.
// Parses sync/device/index/count/data, stages writes, replies with the
// acknowledge and read data, forwards foreign packets, and commits staged
// writes when the acknowledge has left. Assumes a host that waits for the
// reply before sending again (half-duplex).
module uart_reg_slave #(
    parameter int         NREGS     = 16,
    parameter int         TICKW     = 16,
    parameter int         IDLE_BITS = 16,
    parameter logic [7:0] ADDR_RST  = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TICKW-1:0] bit_ticks,
    input  logic             rx_i,
    output logic             tx_o,
    output logic             tx_oe,
    output logic             fwd_valid,
    output logic             fwd_sop,
    output logic [7:0]       fwd_data
);
    import uart_ctl_pkg::*;

    localparam int RAW = $clog2(NREGS);
    localparam logic [8:0] NREGS9 = 9'(NREGS);

    parse_state_e state;
    logic         rx_en, rx_valid, rx_err, idle_to;
    logic [7:0]   rx_byte;
    logic         tx_start, tx_busy, tx_done;
    logic [7:0]   tx_data;
    logic         rd_op, ack_phase;
    logic [7:0]   base_q, count_q, idx_q;
    logic [8:0]   off;
    logic         in_range;
    logic [7:0]   rd_data, rd_byte, own_addr;
    logic         stage_en, commit, discard;

    assign rx_en    = (state != P_REPLY);
    assign off      = {1'b0, base_q} + {1'b0, idx_q};
    assign in_range = (off < NREGS9);
    assign rd_byte  = in_range ? rd_data : 8'h00;
    assign stage_en = (state == P_WDATA) && rx_valid && in_range;
    assign commit   = tx_done && ack_phase && !rd_op;
    assign discard  = (state != P_REPLY) && (rx_err || idle_to);

    uart_rs_rx #(.TICKW(TICKW), .IDLE_BITS(IDLE_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .bit_ticks(bit_ticks),
        .rx_i(rx_i), .byte_valid(rx_valid), .byte_data(rx_byte),
        .frame_err(rx_err), .idle_to(idle_to)
    );

    uart_rs_tx #(.TICKW(TICKW)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_ticks(bit_ticks), .start(tx_start),
        .data(tx_data), .line(tx_o), .busy(tx_busy), .done(tx_done)
    );

    uart_rs_regs #(.NREGS(NREGS), .ADDR_RST(ADDR_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .stage_en(stage_en),
        .stage_idx(off[RAW-1:0]), .stage_data(rx_byte), .commit(commit),
        .discard(discard), .rd_idx(off[RAW-1:0]), .rd_data(rd_data),
        .own_addr(own_addr)
    );

    // Packet parser, reply sequencer and forwarding strobe generator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= P_WAIT_SYNC;
            rd_op     <= 1'b0;
            ack_phase <= 1'b0;
            base_q    <= '0;
            count_q   <= '0;
            idx_q     <= '0;
            tx_start  <= 1'b0;
            tx_data   <= '0;
            tx_oe     <= 1'b0;
            fwd_valid <= 1'b0;
            fwd_sop   <= 1'b0;
            fwd_data  <= '0;
        end else begin
            tx_start  <= 1'b0;
            fwd_valid <= 1'b0;
            fwd_sop   <= 1'b0;
            case (state)
                P_WAIT_SYNC: begin
                    if (rx_valid && rx_byte == SYNC_BYTE) begin
                        state <= P_DEVICE;
                    end
                end
                P_DEVICE: begin
                    if (rx_valid) begin
                        if (rx_byte[7:1] == own_addr[7:1]) begin
                            rd_op <= rx_byte[0];
                            state <= P_INDEX;
                        end else begin
                            fwd_valid <= 1'b1;
                            fwd_sop   <= 1'b1;
                            fwd_data  <= rx_byte;
                            state     <= P_FORWARD;
                        end
                    end
                end
                P_INDEX: begin
                    if (rx_valid) begin
                        base_q <= rx_byte;
                        state  <= P_COUNT;
                    end
                end
                P_COUNT: begin
                    if (rx_valid) begin
                        count_q <= rx_byte;
                        idx_q   <= '0;
                        if (rd_op || rx_byte == 8'h00) begin
                            state     <= P_REPLY;
                            tx_start  <= 1'b1;
                            tx_data   <= ACK_BYTE;
                            ack_phase <= 1'b1;
                            tx_oe     <= 1'b1;
                        end else begin
                            state <= P_WDATA;
                        end
                    end
                end
                P_WDATA: begin
                    if (rx_valid) begin
                        if (idx_q == count_q - 8'd1) begin
                            idx_q     <= '0;
                            state     <= P_REPLY;
                            tx_start  <= 1'b1;
                            tx_data   <= ACK_BYTE;
                            ack_phase <= 1'b1;
                            tx_oe     <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 8'd1;
                        end
                    end
                end
                P_FORWARD: begin
                    if (rx_valid) begin
                        fwd_valid <= 1'b1;
                        fwd_data  <= rx_byte;
                    end
                end
                P_REPLY: begin
                    if (tx_done && !tx_busy) begin
                        ack_phase <= 1'b0;
                        if (rd_op && idx_q != count_q) begin
                            tx_start <= 1'b1;
                            tx_data  <= rd_byte;
                            idx_q    <= idx_q + 8'd1;
                        end else begin
                            state <= P_WAIT_SYNC;
                            tx_oe <= 1'b0;
                        end
                    end
                end
                default: state <= P_WAIT_SYNC;
            endcase
            if (discard) begin
                state <= P_WAIT_SYNC;
            end
        end
    end
endmodule

// Checker: timing relations of the reply line, forwarding port and commit.
module uart_reg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_o,
    input logic       tx_oe,
    input logic       fwd_valid,
    input logic       fwd_sop,
    input logic       commit,
    input logic       rx_en,
    input logic [7:0] own_addr
);
    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> tx_o); // R11
    AST_NO_FWD_IN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe |-> !fwd_valid); // R11
    AST_SOP_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_sop |-> fwd_valid); // R8
    AST_COMMIT_IN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> tx_oe); // R5
    AST_ADDR_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (own_addr != $past(own_addr)) |-> $past(commit)); // R12
    AST_RX_MUTED_IN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> !rx_en); // R11
endmodule

bind uart_reg_slave uart_reg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .tx_oe(tx_oe),
    .fwd_valid(fwd_valid), .fwd_sop(fwd_sop), .commit(commit),
    .rx_en(rx_en), .own_addr(own_addr)
);

// File: tb/tb_uart_reg_slave.sv
module tb_uart_reg_slave;
    localparam int BT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bit_ticks = 16'(BT);
    logic        rx_i = 1'b1;
    logic        tx_o, tx_oe, fwd_valid, fwd_sop;
    logic [7:0]  fwd_data;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mon_b [0:255];
    int mon_cnt = 0, mon_bad = 0, idle_bad = 0, oe_rises = 0, exp_replies = 0;
    logic [7:0] fwd_b [0:63];
    int fwd_cnt = 0, sop_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_reg_slave dut (
        .clk(clk), .rst_n(rst_n), .bit_ticks(bit_ticks), .rx_i(rx_i),
        .tx_o(tx_o), .tx_oe(tx_oe), .fwd_valid(fwd_valid),
        .fwd_sop(fwd_sop), .fwd_data(fwd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reply line decoder: frames, parity and stop bit per R2.
    initial begin
        forever begin
            logic [7:0] d;
            logic p, s;
            @(negedge tx_o);
            repeat (BT/2) @(negedge clk);
            if (tx_o !== 1'b0) mon_bad++;
            for (int k = 0; k < 8; k++) begin
                repeat (BT) @(negedge clk);
                d[k] = tx_o;
            end
            repeat (BT) @(negedge clk); p = tx_o;
            repeat (BT) @(negedge clk); s = tx_o;
            if (s !== 1'b1 || (^{d, p}) !== 1'b0) mon_bad++;
            mon_b[mon_cnt[7:0]] = d;
            mon_cnt++;
        end
    end

    // Line idle and enable pulse monitor, forwarding port logger.
    always @(negedge clk) begin
        if (rst_n && !tx_oe && tx_o !== 1'b1) idle_bad++;
        if (rst_n && fwd_valid) begin
            fwd_b[fwd_cnt[5:0]] = fwd_data;
            fwd_cnt++;
            if (fwd_sop) sop_cnt++;
        end
    end
    always @(posedge tx_oe) oe_rises++;

    task automatic send_byte(input logic [7:0] b, input bit bad_par = 0, input bit bad_stop = 0);
        logic [10:0] f;
        f = {~bad_stop, (^b) ^ bad_par, b, 1'b0};
        for (int k = 0; k < 11; k++) begin
            @(negedge clk); rx_i = f[k];
            repeat (BT-1) @(negedge clk);
        end
        @(negedge clk); rx_i = 1'b1;
    endtask

    task automatic wait_bytes(input int target);
        for (int c = 0; c < 400 * 12 && mon_cnt < target; c++) @(negedge clk);
        wait (!tx_oe);
        repeat (2) @(negedge clk);
    endtask

    task automatic gap(input int bits);
        repeat (bits * BT) @(negedge clk);
    endtask

    task automatic read_pkt(input logic [7:0] dev, input logic [7:0] idx, input logic [7:0] n, output int base);
        base = mon_cnt;
        send_byte(8'h79); send_byte(dev); send_byte(idx); send_byte(n);
        wait_bytes(base + 1 + n);
        exp_replies++;
    endtask

    task automatic t_reset;
        chk(tx_o === 1'b1, "R1 tx_o", tx_o, 1);
        chk(tx_oe === 1'b0, "R1 tx_oe", tx_oe, 0);
        chk(fwd_valid === 1'b0, "R1 fwd_valid", fwd_valid, 0);
    endtask

    task automatic t_default_read;
        int b;
        read_pkt(8'h81, 8'h00, 8'd2, b);
        chk(mon_b[b] == 8'hC3, "R6 ack", mon_b[b], 8'hC3);
        chk(mon_b[b+1] == 8'h80, "R1 addr reset", mon_b[b+1], 8'h80);
        chk(mon_b[b+2] == 8'h00, "R1 reg1 reset", mon_b[b+2], 8'h00);
    endtask

    task automatic t_write_read;
        int b;
        b = mon_cnt;
        send_byte(8'h79); send_byte(8'h80); send_byte(8'h02); send_byte(8'd3);
        send_byte(8'hA5); send_byte(8'h5A); send_byte(8'h3C);
        wait_bytes(b + 1); exp_replies++;
        chk(mon_cnt == b + 1 && mon_b[b] == 8'hC3, "R4 write ack", mon_b[b], 8'hC3);
        read_pkt(8'h81, 8'h02, 8'd3, b);
        chk(mon_b[b+1] == 8'hA5, "R6 reg2", mon_b[b+1], 8'hA5);
        chk(mon_b[b+2] == 8'h5A, "R6 reg3", mon_b[b+2], 8'h5A);
        chk(mon_b[b+3] == 8'h3C, "R4 reg4", mon_b[b+3], 8'h3C);
    endtask

    task automatic t_range;
        int b;
        b = mon_cnt;
        send_byte(8'h79); send_byte(8'h80); send_byte(8'h0F); send_byte(8'd2);
        send_byte(8'h11); send_byte(8'h22);
        wait_bytes(b + 1); exp_replies++;
        chk(mon_b[b] == 8'hC3, "R7 ack", mon_b[b], 8'hC3);
        read_pkt(8'h81, 8'h0F, 8'd3, b);
        chk(mon_b[b+1] == 8'h11, "R7 reg15", mon_b[b+1], 8'h11);
        chk(mon_b[b+2] == 8'h00 && mon_b[b+3] == 8'h00, "R6 out of range", mon_b[b+2], 0);
        read_pkt(8'h81, 8'h00, 8'd1, b);
        chk(mon_b[b+1] == 8'h80, "R7 reg0 untouched", mon_b[b+1], 8'h80);
    endtask

    task automatic t_junk;
        int b;
        b = mon_cnt;
        send_byte(8'h55); send_byte(8'h81); send_byte(8'h02); send_byte(8'h01);
        gap(20);
        chk(mon_cnt == b, "R3 junk ignored", mon_cnt - b, 0);
        read_pkt(8'h81, 8'h03, 8'd1, b);
        chk(mon_b[b+1] == 8'h5A, "R3 after junk", mon_b[b+1], 8'h5A);
    endtask

    task automatic t_errors;
        int b;
        b = mon_cnt;
        send_byte(8'h79); send_byte(8'h80); send_byte(8'h02); send_byte(8'd2);
        send_byte(8'h01); send_byte(8'h02, 1);
        gap(20);
        chk(mon_cnt == b, "R9 parity no ack", mon_cnt - b, 0);
        b = mon_cnt;
        send_byte(8'h79); send_byte(8'h80); send_byte(8'h02); send_byte(8'd2);
        send_byte(8'h07, 0, 1); send_byte(8'h08);
        gap(20);
        chk(mon_cnt == b, "R9 stop no ack", mon_cnt - b, 0);
        read_pkt(8'h81, 8'h02, 8'd2, b);
        chk(mon_b[b+1] == 8'hA5 && mon_b[b+2] == 8'h5A, "R9 discarded",
            {mon_b[b+1], mon_b[b+2]}, 16'hA55A);
    endtask

    task automatic t_forward;
        int b, f, s;
        b = mon_cnt; f = fwd_cnt; s = sop_cnt;
        send_byte(8'h79); send_byte(8'h42); send_byte(8'h07); send_byte(8'h99);
        gap(20);
        chk(mon_cnt == b, "R8 no reply", mon_cnt - b, 0);
        chk(fwd_cnt == f + 3 && sop_cnt == s + 1, "R8 strobes", fwd_cnt - f, 3);
        chk(fwd_b[f[5:0]] == 8'h42 && fwd_b[6'(f+1)] == 8'h07 && fwd_b[6'(f+2)] == 8'h99,
            "R8 bytes", fwd_b[f[5:0]], 8'h42);
    endtask

    task automatic t_idle;
        int b;
        b = mon_cnt;
        send_byte(8'h79);
        gap(20);
        send_byte(8'h81); send_byte(8'h02); send_byte(8'h01);
        gap(20);
        chk(mon_cnt == b, "R10 gap resets", mon_cnt - b, 0);
        read_pkt(8'h81, 8'h04, 8'd1, b);
        chk(mon_b[b+1] == 8'h3C, "R10 recovers", mon_b[b+1], 8'h3C);
    endtask

    task automatic t_new_addr;
        int b, f;
        b = mon_cnt;
        send_byte(8'h79); send_byte(8'h80); send_byte(8'h00); send_byte(8'd1);
        send_byte(8'h90);
        for (int c = 0; c < 2000 && mon_cnt < b + 1; c++) @(negedge clk);
        wait (!tx_oe); exp_replies++;
        b = mon_cnt;
        send_byte(8'h79); send_byte(8'h91); send_byte(8'h00); send_byte(8'd1);
        wait_bytes(b + 2); exp_replies++;
        chk(mon_cnt == b + 2 && mon_b[b+1] == 8'h90, "R5 R12 new address", mon_b[b+1], 8'h90);
        b = mon_cnt; f = fwd_cnt;
        send_byte(8'h79); send_byte(8'h81); send_byte(8'h00); send_byte(8'd1);
        gap(20);
        chk(mon_cnt == b && fwd_cnt == f + 3, "R12 old address forwarded", fwd_cnt - f, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset;
        t_default_read;
        t_write_read;
        t_range;
        t_junk;
        t_errors;
        t_forward;
        t_idle;
        t_new_addr;
        chk(mon_bad == 0, "R2 reply framing", mon_bad, 0);
        chk(idle_bad == 0, "R11 idle line", idle_bad, 0);
        chk(oe_rises == exp_replies, "R11 enable pulses", oe_rises, exp_replies);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule